// File: doc/BRIEF.md
# Alternating push-pull PWM controller

This block is a fixed-frequency pulse-width controller for a push-pull power stage. A free-running counter sets the oscillator period. The last few counts of each period form the internal clock pulse, and during that pulse both gate outputs are held low. The falling edge of the clock pulse starts a new drive pulse. That pulse goes to gate A and gate B in turn, so each gate switches at half the oscillator rate and its duty cycle always stays below one half.

Three comparator results can end a drive pulse: a ramp crossing (`pwm_trip`), a current-limit level (`ilim_trip`) and an overcurrent level (`oc_trip`). The first two are masked for a programmable number of cycles after the pulse starts, so that switching noise at the leading edge is ignored. Either of them ends only the current pulse. The overcurrent input is never masked. It drops both gates in the same cycle and sets a fault latch, which stays set until a clear pulse arrives.

The steering state machine has five states:
- `ST_WAIT`: idle; used for the clock interval and for re-arming.
- `ST_DRIVE_A` and `ST_DRIVE_B`: the named gate is high.
- `ST_HOLD`: the pulse has ended early; the gates stay low until the next period.
- `ST_FAULT`: the fault is latched.

The transitions are:
- start: from `ST_WAIT` or `ST_HOLD` to a drive state, on the last count of the period, choosing the gate by the toggle bit.
- window end: from a drive state to `ST_WAIT`, on the last count before the clock pulse.
- terminate: from a drive state to `ST_HOLD`.
- trip: from any state to `ST_FAULT`, when `oc_trip` is high.
- rearm: from `ST_FAULT` to `ST_WAIT`.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: After reset, both gates, `fault` and `clk_pulse` are low and the counter is at 0. The first period after reset produces no pulse. The first pulse goes to gate A and starts at counter value 0 of the second period.
- R2: Drive pulses alternate between gate A and gate B, one pulse per period. The two gates are never high together.
- R3: `clk_pulse` is high for the last L counts of each period (counter values PERIOD-L to PERIOD-1), and both gates are low while it is high. L is `clk_len`, with 0 treated as 1 and values of PERIOD or more treated as PERIOD-1.
- R4: The selected gate goes high in the cycle where `clk_pulse` falls (counter value 0). With no termination, it stays high for exactly PERIOD-L cycles.
- R5: If `pwm_trip` is high at counter value k after blanking, the gate is high through count k and low from k+1 to the end of the period. Deasserting the input does not restart the pulse.
- R6: While the counter is below `blank_len`, `pwm_trip` and `ilim_trip` are ignored. A `blank_len` of 0 disables blanking. A `blank_len` at least as long as the drive window suppresses both terminations for the whole pulse.
- R7: `ilim_trip`, once past blanking, ends the pulse in the same way as `pwm_trip`, for that period only. The next pulse has its normal width.
- R8: `oc_trip` is never blanked. It forces both gates low in the same cycle and sets `fault` at the next clock edge.
- R9: `fault` stays high until `fault_clr` is seen high while `oc_trip` is low. After the clear, the next pulse goes to gate A, starting at the next falling edge of `clk_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_trip | input | 1 | Ramp crossed the control level |
| ilim_trip | input | 1 | Current above the per-cycle limit |
| oc_trip | input | 1 | Current above the overcurrent level |
| fault_clr | input | 1 | Clears the fault latch |
| blank_len | input | CNT_W | Leading-edge blanking length in cycles |
| clk_len | input | CNT_W | Length of the clock interval at the end of the period |
| gate_a | output | 1 | Drive output A |
| gate_b | output | 1 | Drive output B |
| fault | output | 1 | Overcurrent fault latched |
| clk_pulse | output | 1 | Internal clock pulse |

## Verification
The hardest case to reach is a fault recovery in which the toggle bit would have chosen gate B. Only that case shows that the clear forces gate A rather than simply carrying on the alternation. The stimulus fires the overcurrent on a gate-A pulse, which leaves the toggle pointing at B. It then waits out a faulted period, pulses the clear at the start of the following period and checks that the next pulse is on gate A. Every termination input is applied as a one-cycle pulse at a chosen counter value. This sets the blanking boundary, the termination point and the end of the window one count apart, and a behavioural model is compared with the design on every clock.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;

    typedef enum logic [2:0] {
        ST_WAIT    = 3'd0,
        ST_DRIVE_A = 3'd1,
        ST_DRIVE_B = 3'd2,
        ST_HOLD    = 3'd3,
        ST_FAULT   = 3'd4
    } pp_state_t;

    localparam int unsigned NUM_GATES = 2;

endpackage

// File: rtl/pp_osc.sv
module pp_osc #(
    parameter int PERIOD = 32,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] clk_len,
    output logic [CNT_W-1:0] cnt,
    output logic             clk_pulse,
    output logic             period_end,
    output logic             window_last
);

    localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] P_W   = CNT_W'(PERIOD);
    localparam logic [CNT_W-1:0] ONE_W = CNT_W'(1);

    logic [CNT_W-1:0] len_eff;
    logic [CNT_W-1:0] clk_start;

    // clock interval length limited to 1..PERIOD-1
    always_comb begin
        if (clk_len == '0) begin
            len_eff = ONE_W;
        end else if (clk_len > LAST) begin
            len_eff = LAST;
        end else begin
            len_eff = clk_len;
        end
    end

    assign clk_start = P_W - len_eff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE_W;
        end
    end

    assign clk_pulse   = (cnt >= clk_start);
    assign period_end  = (cnt == LAST);
    assign window_last = (cnt == (clk_start - ONE_W));

endmodule

// File: rtl/pp_blank.sv
module pp_blank #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] blank_len,
    input  logic             pwm_trip,
    input  logic             ilim_trip,
    output logic             term_req
);

    logic unmasked;

    // pulses always begin at count 0, so the count is the age of the pulse
    assign unmasked = (cnt >= blank_len);
    assign term_req = unmasked && (pwm_trip || ilim_trip);

endmodule

// File: rtl/pp_steer.sv
module pp_steer
    import pp_pwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 period_end,
    input  logic                 window_last,
    input  logic                 term_req,
    input  logic                 oc_trip,
    input  logic                 fault_clr,
    output logic [NUM_GATES-1:0] gate,
    output logic                 fault
);

    pp_state_t state_q, state_d;
    logic      sel_q, sel_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_FAULT: begin
                if (fault_clr && !oc_trip) begin
                    state_d = ST_WAIT;
                    sel_d   = 1'b0;
                end
            end
            ST_WAIT, ST_HOLD: begin
                if (oc_trip) begin
                    state_d = ST_FAULT;
                end else if (period_end) begin
                    state_d = sel_q ? ST_DRIVE_B : ST_DRIVE_A;
                    sel_d   = ~sel_q;
                end
            end
            ST_DRIVE_A, ST_DRIVE_B: begin
                if (oc_trip) begin
                    state_d = ST_FAULT;
                end else if (window_last) begin
                    state_d = ST_WAIT;
                end else if (term_req) begin
                    state_d = ST_HOLD;
                end
            end
            default: begin
                state_d = ST_WAIT;
            end
        endcase
    end

    // Moore outputs, gated without delay by the unblanked overcurrent input
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_lane
        localparam pp_state_t LANE_ST = (g == 0) ? ST_DRIVE_A : ST_DRIVE_B;
        assign gate[g] = (state_q == LANE_ST) && !oc_trip;
    end

    assign fault = (state_q == ST_FAULT);

endmodule

// File: rtl/pp_pwm_ctrl.sv
module pp_pwm_ctrl
    import pp_pwm_pkg::*;
#(
    parameter int PERIOD = 32,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_trip,
    input  logic             ilim_trip,
    input  logic             oc_trip,
    input  logic             fault_clr,
    input  logic [CNT_W-1:0] blank_len,
    input  logic [CNT_W-1:0] clk_len,
    output logic             gate_a,
    output logic             gate_b,
    output logic             fault,
    output logic             clk_pulse
);

    logic [CNT_W-1:0]     osc_cnt;
    logic                 period_end;
    logic                 window_last;
    logic                 term_req;
    logic [NUM_GATES-1:0] gate;

    pp_osc #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_osc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_len     (clk_len),
        .cnt         (osc_cnt),
        .clk_pulse   (clk_pulse),
        .period_end  (period_end),
        .window_last (window_last)
    );

    pp_blank #(.CNT_W(CNT_W)) u_blank (
        .cnt       (osc_cnt),
        .blank_len (blank_len),
        .pwm_trip  (pwm_trip),
        .ilim_trip (ilim_trip),
        .term_req  (term_req)
    );

    pp_steer u_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_end  (period_end),
        .window_last (window_last),
        .term_req    (term_req),
        .oc_trip     (oc_trip),
        .fault_clr   (fault_clr),
        .gate        (gate),
        .fault       (fault)
    );

    assign gate_a = gate[0];
    assign gate_b = gate[1];

endmodule

// File: rtl/pp_pwm_checker.sv
module pp_pwm_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_trip,
    input logic             ilim_trip,
    input logic             oc_trip,
    input logic             fault_clr,
    input logic [CNT_W-1:0] blank_len,
    input logic             gate_a,
    input logic             gate_b,
    input logic             fault,
    input logic             clk_pulse,
    input logic [CNT_W-1:0] osc_cnt
);

    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_a && gate_b));

    a_r3_low_in_clock: assert property (@(posedge clk) disable iff (!rst_n)
        clk_pulse |-> (!gate_a && !gate_b));

    a_r4_a_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_a) |-> ($past(clk_pulse) && !clk_pulse));

    a_r4_b_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_b) |-> ($past(clk_pulse) && !clk_pulse));

    a_r5_pwm_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_a && pwm_trip && (osc_cnt >= blank_len)) |=> !gate_a);

    a_r7_ilim_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_b && ilim_trip && (osc_cnt >= blank_len)) |=> !gate_b);

    a_r8_oc_drops_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> (!gate_a && !gate_b));

    a_r8_oc_sets_fault: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |=> fault);

    a_r9_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);

endmodule

bind pp_pwm_ctrl pp_pwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_trip  (pwm_trip),
    .ilim_trip (ilim_trip),
    .oc_trip   (oc_trip),
    .fault_clr (fault_clr),
    .blank_len (blank_len),
    .gate_a    (gate_a),
    .gate_b    (gate_b),
    .fault     (fault),
    .clk_pulse (clk_pulse),
    .osc_cnt   (osc_cnt)
);

// File: tb/pp_pwm_ctrl_test.sv
`timescale 1ns/1ps
module pp_pwm_ctrl_test;

    localparam int P = 32;
    localparam int W = $clog2(P);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwm_trip = 1'b0, ilim_trip = 1'b0, oc_trip = 1'b0, fault_clr = 1'b0;
    logic [W-1:0] blank_len = '0;
    logic [W-1:0] clk_len = W'(4);
    logic         gate_a, gate_b, fault, clk_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt, m_sel, m_on, m_fault;
    int seen_a, seen_b;

    always #2.5 clk = ~clk;

    pp_pwm_ctrl #(.PERIOD(P)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_trip(pwm_trip), .ilim_trip(ilim_trip),
        .oc_trip(oc_trip), .fault_clr(fault_clr), .blank_len(blank_len),
        .clk_len(clk_len), .gate_a(gate_a), .gate_b(gate_b), .fault(fault),
        .clk_pulse(clk_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_len(input int d);
        if (d == 0) return 1;
        if (d >= P) return P - 1;
        return d;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_sel = 0; m_on = 0; m_fault = 0;
    endtask

    task automatic model_step();
        int dl = eff_len(int'(clk_len));
        if (m_fault != 0) begin
            if (fault_clr && !oc_trip) begin
                m_fault = 0; m_sel = 0; m_on = 0;
            end
        end else if (oc_trip) begin
            m_fault = 1; m_on = 0;
        end else if (m_cnt == P - 1) begin
            m_on = m_sel + 1;
            m_sel = 1 - m_sel;
        end else if (m_on != 0) begin
            if (m_cnt == P - dl - 1) m_on = 0;
            else if (m_cnt >= int'(blank_len) && (pwm_trip || ilim_trip)) m_on = 0;
        end
        m_cnt = (m_cnt + 1) % P;
    endtask

    // one clock: compare against the model, then advance both
    task automatic cyc();
        int ea, eb, ec;
        #1;
        ea = (m_on == 1 && !oc_trip && m_fault == 0) ? 1 : 0;
        eb = (m_on == 2 && !oc_trip && m_fault == 0) ? 1 : 0;
        ec = (m_cnt >= P - eff_len(int'(clk_len))) ? 1 : 0;
        chk("R4 gate_a per-cycle", int'(gate_a), ea);
        chk("R4 gate_b per-cycle", int'(gate_b), eb);
        chk("R3 clk_pulse per-cycle", int'(clk_pulse), ec);
        chk("R9 fault per-cycle", int'(fault), m_fault);
        seen_a += int'(gate_a);
        seen_b += int'(gate_b);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    // one full period from count 0; each *_at is a one-cycle pulse at that count
    task automatic run_period(input int pwm_at, input int ilim_at, input int oc_at,
                              input int clr_at, output int ah, output int bh);
        seen_a = 0; seen_b = 0;
        for (int i = 0; i < P; i++) begin
            pwm_trip  = (i == pwm_at);
            ilim_trip = (i == ilim_at);
            oc_trip   = (i == oc_at);
            fault_clr = (i == clr_at);
            cyc();
        end
        pwm_trip = 0; ilim_trip = 0; oc_trip = 0; fault_clr = 0;
        ah = seen_a; bh = seen_b;
    endtask

    initial begin
        int ah, bh;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset gate_a", int'(gate_a), 0);
        chk("R1 reset gate_b", int'(gate_b), 0);
        chk("R1 reset fault", int'(fault), 0);
        chk("R1 reset clk_pulse", int'(clk_pulse), 0);

        run_period(-1, -1, -1, -1, ah, bh);
        chk("R1 no pulse in first period", ah + bh, 0);
        run_period(-1, -1, -1, -1, ah, bh);
        chk("R1 first pulse on A", ah, 28);
        chk("R4 full width A", ah + bh, 28);
        run_period(-1, -1, -1, -1, ah, bh);
        chk("R2 second pulse on B", bh, 28);
        chk("R2 A idle on B period", ah, 0);

        clk_len = '0;
        run_period(-1, -1, -1, -1, ah, bh);
        chk("R3 zero length treated as one", ah, 31);
        clk_len = W'(31);
        run_period(-1, -1, -1, -1, ah, bh);
        chk("R3 longest interval leaves one cycle", bh, 1);
        clk_len = W'(4);

        blank_len = W'(3);
        run_period(10, -1, -1, -1, ah, bh);
        chk("R5 pwm at count 10 ends A", ah, 11);
        run_period(1, -1, -1, -1, ah, bh);
        chk("R6 pwm inside blanking ignored", bh, 28);
        blank_len = '0;
        run_period(0, -1, -1, -1, ah, bh);
        chk("R6 zero blanking ends at once", ah, 1);
        blank_len = W'(31);
        run_period(20, 25, -1, -1, ah, bh);
        chk("R6 long blanking suppresses both", bh, 28);
        blank_len = W'(3);
        run_period(-1, 12, -1, -1, ah, bh);
        chk("R7 ilim at count 12 ends A", ah, 13);
        run_period(-1, -1, -1, -1, ah, bh);
        chk("R7 next pulse full width", bh, 28);

        run_period(-1, -1, 5, -1, ah, bh);
        chk("R8 oc at count 5 ends A", ah, 5);
        chk("R8 fault latched", int'(fault), 1);
        run_period(-1, -1, -1, -1, ah, bh);
        chk("R9 no pulses while faulted", ah + bh, 0);
        chk("R9 fault still held", int'(fault), 1);
        run_period(-1, -1, -1, 0, ah, bh);
        chk("R9 clear period quiet", ah + bh, 0);
        chk("R9 fault cleared", int'(fault), 0);
        run_period(-1, -1, -1, -1, ah, bh);
        chk("R9 restart on A", ah, 28);
        chk("R9 B idle on restart", bh, 0);
        run_period(-1, -1, 1, -1, ah, bh);
        chk("R8 oc inside blanking not masked", bh, 1);
        chk("R8 fault after unblanked oc", int'(fault), 1);

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule